// File: doc/BRIEF.md
# Framed SPI Command Receiver

This block is the serial front end of a small register-controlled peripheral. A host shifts 24-bit command words into it, most significant bit first, while holding an active-low chip select. Each word carries a 4-bit operation code in the top nibble, a 4-bit register address in the next nibble and a 16-bit data value in the low half. When chip select returns high, the receiver checks that the frame held a whole number of words. If so, it hands the last word to a register back end as a one-cycle strobe in the system clock domain. Frames of the wrong length are dropped. A chip-select pulse with no clocks re-issues the command executed most recently.

The serial pins are asynchronous to the system clock. The block oversamples them through a synchronizer and detects the clock edges with logic. It accepts both the idle-low clock mode with sampling on the leading edge and the idle-high mode with sampling on the trailing edge. In both modes input bits are taken on the rising edge and output bits change on the falling edge.

The serial output is a data bit plus an output enable. When the previous command was a read, the output shifts the read word back during the next frame. Otherwise it repeats the input stream 24 clocks late, so devices can be chained output to input.

Top module: `spi_cmd_rx`

## Requirements
- R1: A word is decoded with input bits 23..20 as `cmd_code`, bits 19..16 as `cmd_addr` and bits 15..0 as `cmd_data`, where bit 23 is the first bit shifted in.
- R2: A frame of 24·k rising clock edges (k ≥ 1) produces exactly one `cmd_valid` pulse carrying the last 24 bits received.
- R3: A frame whose edge count is not a multiple of 4 produces no `cmd_valid` pulse and leaves the stored command unchanged.
- R4: A frame whose edge count is a multiple of 4 but not a multiple of 24 produces no `cmd_valid` pulse and leaves the stored command unchanged.
- R5: A chip-select pulse with no clock edges repeats the last executed command as a new `cmd_valid` pulse. Before any command has been executed after reset, such a pulse produces nothing.
- R6: Frames sent with the clock idling high (first edge falling) decode the same as frames with the clock idling low.
- R7: `sdo_oe` is 0 in reset, 0 while chip select is high and 1 during a frame.
- R8: After a command with code 9 or 10 executes (including by replay), the next frame drives `sdo` with the 24-bit word {that code, that address, `rd_data`}, MSB first. The first bit is valid before the first rising clock edge.
- R9: After any other command, or after reset, `sdo` during a frame is 0 for the first 24 bits. Bit i (i ≥ 24) equals input bit i−24.
- R10: `cmd_valid` lasts exactly one system clock cycle, rises within six system clock cycles of chip select going high, and is never asserted during a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sclk | input | 1 | Serial clock, asynchronous |
| spi_sdi | input | 1 | Serial data in |
| rd_data | input | 16 | Read-back value from the back end for the pending read |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means the line is released |
| cmd_valid | output | 1 | One-cycle strobe for an accepted or replayed command |
| cmd_code | output | 4 | Operation code of the command |
| cmd_addr | output | 4 | Register address of the command |
| cmd_data | output | 16 | Data field of the command |

## Verification
The command strobe appears three to four system cycles after chip select rises: two synchronizer stages, one edge-detect compare and one output register. The bench therefore never waits for a fixed cycle. A frame task pushes the expected word into a scoreboard queue before releasing chip select. A monitor compares each strobe against the queue whenever it arrives, and any strobe with an empty queue counts as a rejected frame that leaked through. A serial output bit settles about three cycles after the falling clock edge that shifts it. The bench samples it six cycles later, on a falling system edge just before the next rising serial edge. The output enable is checked twelve cycles after chip select rises, when the synchronizer has settled.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int CODE_W = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int WORD_W = CODE_W + ADDR_W + DATA_W;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_word_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= INIT;
          else     stage_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= INIT;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall,
  input  logic              cs_low,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  input  logic              load_rd,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] word,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [WORD_W-1:0] shreg_q;
  logic              sdo_q;
  logic              oe_q;

  // One register serves capture and output: its top bit is either the
  // preloaded read word or the input bit received 24 edges earlier.
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
    end else if (cs_fall) begin
      shreg_q <= load_rd ? rd_word : '0;
    end else if (sclk_rise) begin
      shreg_q <= {shreg_q[WORD_W-2:0], sdi_s};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_q <= 1'b0;
    end else if (cs_fall) begin
      sdo_q <= load_rd ? rd_word[WORD_W-1] : 1'b0;
    end else if (sclk_fall) begin
      sdo_q <= shreg_q[WORD_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= cs_low;
  end

  assign word   = shreg_q;
  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_cmd_pkg::*;
#(
  parameter int ALIGN     = 4,
  parameter int RD_CODE_A = 9,
  parameter int RD_CODE_B = 10
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cs_fall,
  input  logic      cs_rise,
  input  logic      sclk_rise,
  input  cmd_word_t word,
  output logic      cmd_valid,
  output cmd_word_t cmd,
  output logic      load_rd
);
  localparam int           CNT_W    = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_ALN  = CNT_W'(ALIGN);

  logic [CNT_W-1:0] cnt_q;
  logic             full_q;
  logic             seen_q;
  logic             have_q;
  logic             pend_q;
  logic             valid_q;
  cmd_word_t        cmd_q;

  logic             aligned;
  logic             do_exec;
  logic             do_replay;
  cmd_word_t        next_cmd;
  logic             next_is_rd;

  always_comb begin
    aligned    = (cnt_q % CNT_ALN) == '0;
    do_exec    = cs_rise && seen_q && aligned && (cnt_q == '0) && full_q;
    do_replay  = cs_rise && !seen_q && have_q;
    next_cmd   = do_exec ? word : cmd_q;
    next_is_rd = (next_cmd.code == CODE_W'(RD_CODE_A)) ||
                 (next_cmd.code == CODE_W'(RD_CODE_B));
  end

  // Bit count within the current word, plus a flag for a completed word.
  always_ff @(posedge clk) begin
    if (rst || cs_fall || cs_rise) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      seen_q <= rst ? 1'b0 : (cs_rise ? seen_q : 1'b0);
    end else if (sclk_rise) begin
      seen_q <= 1'b1;
      if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        full_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      cmd_q   <= '0;
      have_q  <= 1'b0;
    end else begin
      valid_q <= do_exec || do_replay;
      if (do_exec) begin
        cmd_q  <= word;
        have_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cs_fall)              pend_q <= 1'b0;
    else if (do_exec || do_replay)   pend_q <= next_is_rd;
  end

  assign cmd_valid = valid_q;
  assign cmd       = cmd_q;
  assign load_rd   = pend_q;
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ALIGN       = 4,
  parameter int RD_CODE_A   = 9,
  parameter int RD_CODE_B   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              cmd_valid,
  output logic [CODE_W-1:0] cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  logic [2:0]        pins_s;
  logic              cs_s, sclk_s, sdi_s;
  logic              cs_d, sclk_d;
  logic              cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic              load_rd;
  logic [WORD_W-1:0] word_raw;
  cmd_word_t         cmd;
  logic [WORD_W-1:0] rd_word;

  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_cs_n, spi_sclk, spi_sdi}),
    .q   (pins_s)
  );

  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  always_comb begin
    cs_fall   = cs_d & ~cs_s;
    cs_rise   = ~cs_d & cs_s;
    sclk_rise = ~sclk_d & sclk_s & ~cs_s;
    sclk_fall = sclk_d & ~sclk_s & ~cs_s;
    rd_word   = {cmd.code, cmd.addr, rd_data};
  end

  spi_word_shifter u_shift (
    .clk       (clk),
    .rst       (rst),
    .cs_fall   (cs_fall),
    .cs_low    (~cs_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdi_s     (sdi_s),
    .load_rd   (load_rd),
    .rd_word   (rd_word),
    .word      (word_raw),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
  );

  spi_frame_ctl #(.ALIGN(ALIGN), .RD_CODE_A(RD_CODE_A), .RD_CODE_B(RD_CODE_B)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_rise (sclk_rise),
    .word      (cmd_word_t'(word_raw)),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .load_rd   (load_rd)
  );

  assign cmd_code = cmd.code;
  assign cmd_addr = cmd.addr;
  assign cmd_data = cmd.data;
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic cmd_valid,
  input logic sdo,
  input logic sdo_oe
);
  logic [2:0] settle_q;

  always_ff @(posedge clk) begin
    if (rst)                 settle_q <= '0;
    else if (settle_q != 3'd7) settle_q <= settle_q + 1'b1;
  end

  // R10: the strobe never stretches over two cycles
  p_valid_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R10: a strobe only follows a released chip select
  p_valid_after_cs_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && settle_q == 3'd7) |-> $past(spi_cs_n));

  // R7: the output is released whenever a command is being handed over
  p_valid_oe_off_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !sdo_oe);

  // R8/R9: the data line only moves while it is driven
  p_sdo_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!sdo_oe && settle_q != 3'd0) |-> $stable(sdo));

  // R7: a long-idle chip select keeps the line released
  p_oe_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (settle_q == 3'd7 && spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !sdo_oe);
endmodule

bind spi_cmd_rx spi_cmd_rx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .spi_cs_n  (spi_cs_n),
  .cmd_valid (cmd_valid),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe)
);

// File: tb/spi_cmd_rx_bench.sv
module spi_cmd_rx_bench;
  localparam int HP     = 6;
  localparam logic [15:0] RDV = 16'hBEEF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_cs_n = 1'b1;
  logic        spi_sclk = 1'b0;
  logic        spi_sdi = 1'b0;
  logic [15:0] rd_data = RDV;
  logic        sdo, sdo_oe, cmd_valid;
  logic [3:0]  cmd_code, cmd_addr;
  logic [15:0] cmd_data;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q [$];
  logic [23:0] last_w = '0;
  bit          have_last = 0;
  bit          pend = 0;

  always #2 clk = ~clk;

  spi_cmd_rx u_spi_cmd_rx (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_sdi(spi_sdi),
    .rd_data(rd_data), .sdo(sdo), .sdo_oe(sdo_oe), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  function automatic bit is_rd(input logic [23:0] w);
    return (w[23:20] == 4'd9) || (w[23:20] == 4'd10);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: pops the scoreboard on every strobe (R1, R2, R5, R10)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && cmd_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3/R4 unexpected strobe", {8'h0, cmd_code, cmd_addr, cmd_data}, 32'h0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk({cmd_code, cmd_addr, cmd_data} == e, "R1/R2 decoded word",
              {8'h0, cmd_code, cmd_addr, cmd_data}, {8'h0, e});
        end
      end
    end
  end

  // Driver: one frame of n bits, MSB first, in either clock mode
  task automatic frame(input logic [71:0] bits, input int n, input bit mode3);
    logic [23:0] pre;
    pre  = pend ? {last_w[23:16], RDV} : 24'h0;
    pend = 0;
    spi_sclk = mode3;
    tick(2);
    spi_cs_n = 1'b0;
    tick(HP);
    for (int i = 0; i < n; i++) begin
      logic e;
      e = (i < 24) ? pre[23-i] : bits[n-1-(i-24)];
      if (mode3) begin spi_sclk = 1'b0; end
      spi_sdi = bits[n-1-i];
      tick(HP);
      @(negedge clk);
      if (i == 0) chk(sdo_oe == 1'b1, "R7 oe in frame", {31'h0, sdo_oe}, 32'h1);
      chk(sdo == e, (i < 24 && pre != 0) ? "R8 read-back bit" : "R9 chained bit",
          {31'h0, sdo}, {31'h0, e});
      tick(0);
      spi_sclk = 1'b1;
      tick(HP);
      if (!mode3) spi_sclk = 1'b0;
    end
    if (n == 0) begin
      if (have_last) begin exp_q.push_back(last_w); pend = is_rd(last_w); end
    end else if (n % 24 == 0) begin
      last_w = bits[23:0];
      have_last = 1;
      exp_q.push_back(last_w);
      pend = is_rd(last_w);
    end
    tick(HP);
    spi_cs_n = 1'b1;
    tick(12);
    @(negedge clk);
    chk(sdo_oe == 1'b0, "R7 oe released", {31'h0, sdo_oe}, 32'h0);
    chk(exp_q.size() == 0, "R10 strobe due", exp_q.size(), 32'h0);
    tick(0);
  endtask

  initial begin
    tick(5);
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R10 reset strobe", {31'h0, cmd_valid}, 32'h0);
    chk(sdo_oe == 1'b0, "R7 reset oe", {31'h0, sdo_oe}, 32'h0);
    rst = 1'b0;
    tick(4);
    frame(72'h0, 0, 0);                              // R5: no history yet
    frame(72'h13_1234, 24, 0);                       // R1, R2, R9
    frame({24'h0, 24'h2A_55AA, 24'h4C_0F0F}, 48, 0); // R2: last word wins, R9 chain
    frame(72'h7F_FFFF >> 1, 23, 0);                  // R3
    frame(72'h1_FFFF_FF, 25, 0);                     // R3
    frame(72'h0A_BCDE_F, 28, 0);                     // R4
    frame(72'h5A5, 12, 0);                           // R4
    frame(72'h0, 0, 0);                              // R5: replay 4C0F0F
    frame(72'h26_C3A1, 24, 1);                       // R6
    frame(72'h97_0000, 24, 0);                       // R8 read code 9
    frame(72'h01_1111, 24, 0);                       // R8 read-back shifted out
    frame(72'hA5_0000, 24, 1);                       // R8 read code 10, mode 3
    frame({24'h0, 24'h33_3333, 24'h08_7654}, 48, 1); // R8 then R9 pass-through
    frame(72'h3, 2, 0);                              // R3 between replays
    frame(72'h0, 0, 1);                              // R5: replay 087654
    tick(20);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule